// File: doc/BRIEF.md
# Command-Gated Serial Register Port

This block is a slave serial port that lets a host reach a small register file over a four-wire serial link. The link has a select input, a serial clock, a data input and a data output. The port runs on the system clock and oversamples the serial pins through synchronizers. Every access opens with an 8-bit command byte. The command names one register and says whether the single transfer that follows is a read or a write. Once that transfer ends, the port expects a new command byte.

The file holds four registers:

- a status byte that carries the data-ready flag,
- a 24-bit configuration word,
- an 8-bit filter word,
- a 16-bit conversion result.

The conversion result is loaded from the converter side. The filter word cannot be written while the converter reports that it is active. A host that has lost framing can recover by driving the data input high for 32 serial clocks in a row. This returns the port to command-wait and restores every register to its reset value.

Top module: `serial_regport`

## Requirements
- R1: After `rst`, `cfg_q` is 000000h, `flt_q` is 45h, `rdy_n` is 1, `dout_oe` is 0, a read of the result register returns 0000h, and the port waits for a command byte.
- R2: The command byte is 8 bits, MSB first, sampled on SCLK rising edges. Bit 6 = 1 selects a read and 0 a write. Bits [1:0] select the register: 00 status, 01 configuration, 10 filter, 11 result. The remaining bits are ignored. Exactly one transfer follows the command, and then the port waits for a command again.
- R3: Transfer lengths are 8 bits for status, 24 for configuration, 8 for filter and 16 for result, MSB first. The transfer begins on the SCLK cycle right after the command's 8th bit, so command and data can run as one continuous stream.
- R4: In a read, `dout` changes on SCLK falling edges and presents the MSB after the first falling edge that follows the command. `dout_oe` is 1 while `cs_n` is low and 0 while it is high.
- R5: A completed configuration write places the 24 received bits on `cfg_q`.
- R6: A completed filter write updates `flt_q` only when `conv_active` is 0. When `conv_active` is 1 the write is refused and `flt_q` keeps its value.
- R7: Writes aimed at status or result consume their bits and change nothing.
- R8: An `upd_valid` pulse loads `upd_data` into the result register and drives `rdy_n` low. Status reads return the ready flag in bit 7 and zeros in bits [6:0].
- R9: Completing a full result read sets `rdy_n` high, unless an update arrives in the same cycle. The same result can be read again.
- R10: A read shifts out the value the register held when the command byte completed. An update that lands in the middle of the read does not change the word being shifted out.
- R11: 32 consecutive SCLK rising edges with `din` = 1 return the port to command-wait and restore all registers to their reset values. A run of 31 ones followed by a 0 has no such effect.
- R12: Raising `cs_n` in the middle of a transfer abandons it without any register write. The next frame starts with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for `dout` (tri-state control) |
| conv_active | input | 1 | Converter running; blocks filter writes |
| upd_valid | input | 1 | One-cycle strobe: new conversion result |
| upd_data | input | 16 | New conversion result |
| rdy_n | output | 1 | Low while an unread result is waiting |
| cfg_q | output | 24 | Configuration word |
| flt_q | output | 8 | Filter word |

## Verification
A bit counter that drifts shows up at the ports within one frame. The next command byte is decoded out of phase, so a read returns shifted or wrong data, or a write lands in the wrong register. A ones counter that is off by one shows up either as a missing reset after 32 ones or as a false reset after 31. The 31-ones boundary is checked by reading the configuration back afterwards. A stale ready flag shows on `rdy_n` and in status bit 7 within a few system clocks of the end of the read. A snapshot fault appears as a mixed word when an update is injected in the middle of a read.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int CMD_W    = 8;
  localparam int STAT_W   = 8;
  localparam int CFG_W    = 24;
  localparam int FLT_W    = 8;
  localparam int DAT_W    = 16;
  localparam int XFER_MAX = CFG_W;
  localparam int CNT_W    = $clog2(XFER_MAX);
  localparam int RD_BIT   = 6;
  localparam logic [FLT_W-1:0] FLT_RST = 8'h45;
  localparam logic [CFG_W-1:0] CFG_RST = '0;
  localparam logic [DAT_W-1:0] DAT_RST = '0;

  typedef enum logic [1:0] {
    SEL_STAT = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_FLT  = 2'b10,
    SEL_DAT  = 2'b11
  } sel_e;

  typedef enum logic {PH_CMD, PH_XFER} phase_e;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sif_frame.sv
module sif_frame
  import sif_pkg::*;
#(
  parameter int ONES_LIMIT = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_s,
  input  logic                cs_n_s,
  input  logic                din_s,
  input  logic [XFER_MAX-1:0] rd_word,
  output sel_e                rd_sel,
  output logic                wr_stb,
  output sel_e                wr_sel,
  output logic [XFER_MAX-1:0] wr_data,
  output logic                rd_done,
  output logic                ones_rst,
  output logic                dout,
  output logic                dout_oe
);
  localparam int ONES_W = $clog2(ONES_LIMIT + 1);

  phase_e              phase;
  logic [CNT_W-1:0]    bitcnt, len_m1;
  logic [ONES_W-1:0]   ones_cnt;
  logic [XFER_MAX-2:0] shin;
  logic [XFER_MAX-1:0] shout;
  logic                is_rd, sclk_q;
  sel_e                cur_sel;
  logic                rise, fall, sel_on, ones_hit;

  function automatic logic [CNT_W-1:0] len_of(sel_e s);
    case (s)
      SEL_CFG:  return CNT_W'(CFG_W - 1);
      SEL_DAT:  return CNT_W'(DAT_W - 1);
      SEL_FLT:  return CNT_W'(FLT_W - 1);
      default:  return CNT_W'(STAT_W - 1);
    endcase
  endfunction

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign sel_on   = ~cs_n_s;
  assign ones_hit = rise & sel_on & din_s & (ones_cnt == ONES_W'(ONES_LIMIT - 1));
  assign rd_sel   = sel_e'({shin[0], din_s});

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b1;
      dout_oe <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      dout_oe <= sel_on;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      bitcnt   <= '0;
      len_m1   <= '0;
      ones_cnt <= '0;
      shin     <= '0;
      shout    <= '0;
      dout     <= 1'b0;
      is_rd    <= 1'b0;
      cur_sel  <= SEL_STAT;
      wr_stb   <= 1'b0;
      wr_sel   <= SEL_STAT;
      wr_data  <= '0;
      rd_done  <= 1'b0;
      ones_rst <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      rd_done  <= 1'b0;
      ones_rst <= 1'b0;
      if (!sel_on) begin
        phase  <= PH_CMD;
        bitcnt <= '0;
      end else begin
        if (rise) begin
          shin     <= {shin[XFER_MAX-3:0], din_s};
          ones_cnt <= (din_s && !ones_hit) ? ones_cnt + 1'b1 : '0;
          if (ones_hit) begin
            ones_rst <= 1'b1;
            phase    <= PH_CMD;
            bitcnt   <= '0;
          end else if (phase == PH_CMD) begin
            if (bitcnt == CNT_W'(CMD_W - 1)) begin
              phase   <= PH_XFER;
              bitcnt  <= '0;
              is_rd   <= shin[RD_BIT-1];
              cur_sel <= rd_sel;
              len_m1  <= len_of(rd_sel);
              shout   <= rd_word;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end else begin
            if (bitcnt == len_m1) begin
              phase  <= PH_CMD;
              bitcnt <= '0;
              if (!is_rd) begin
                wr_stb  <= 1'b1;
                wr_sel  <= cur_sel;
                wr_data <= {shin, din_s};
              end else if (cur_sel == SEL_DAT) begin
                rd_done <= 1'b1;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        if (fall && phase == PH_XFER && is_rd) begin
          dout  <= shout[XFER_MAX-1];
          shout <= {shout[XFER_MAX-2:0], 1'b0};
        end
      end
    end
  end

  // R11
  ones_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ones_hit |=> (phase == PH_CMD && bitcnt == '0 && ones_rst));

  // R12
  cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_on |=> (phase == PH_CMD && !wr_stb && !rd_done));

  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_XFER) |-> (bitcnt <= len_m1));
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile
  import sif_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  sel_e                wr_sel,
  input  logic [XFER_MAX-1:0] wr_data,
  input  logic                rd_done,
  input  logic                ones_rst,
  input  logic                conv_active,
  input  logic                upd_valid,
  input  logic [DAT_W-1:0]    upd_data,
  input  sel_e                rd_sel,
  output logic [XFER_MAX-1:0] rd_word,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [FLT_W-1:0]    flt_q,
  output logic                rdy_n
);
  logic [DAT_W-1:0] dat_r;
  logic             clear;

  assign clear = rst | ones_rst;

  always_ff @(posedge clk) begin
    if (clear) begin
      cfg_q <= CFG_RST;
      flt_q <= FLT_RST;
      dat_r <= DAT_RST;
      rdy_n <= 1'b1;
    end else begin
      if (wr_stb && wr_sel == SEL_CFG) cfg_q <= wr_data;
      if (wr_stb && wr_sel == SEL_FLT && !conv_active) flt_q <= wr_data[FLT_W-1:0];
      if (upd_valid) begin
        dat_r <= upd_data;
        rdy_n <= 1'b0;
      end else if (rd_done) begin
        rdy_n <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_word = {~rdy_n, {(STAT_W-1){1'b0}}, {(XFER_MAX-STAT_W){1'b0}}};
      SEL_CFG:  rd_word = cfg_q;
      SEL_FLT:  rd_word = {flt_q, {(XFER_MAX-FLT_W){1'b0}}};
      default:  rd_word = {dat_r, {(XFER_MAX-DAT_W){1'b0}}};
    endcase
  end

  // R6
  filter_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_active && !ones_rst) |=> (flt_q == $past(flt_q)));

  // R8
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !ones_rst) |=> !rdy_n);

  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !upd_valid && !ones_rst) |=> rdy_n);
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import sif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ONES_LIMIT  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  input  logic             conv_active,
  input  logic             upd_valid,
  input  logic [DAT_W-1:0] upd_data,
  output logic             rdy_n,
  output logic [CFG_W-1:0] cfg_q,
  output logic [FLT_W-1:0] flt_q
);
  logic [2:0]          pins_s;
  logic [XFER_MAX-1:0] rd_word, wr_data;
  sel_e                rd_sel, wr_sel;
  logic                wr_stb, rd_done, ones_rst;

  sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, cs_n, din}),
    .q   (pins_s)
  );

  sif_frame #(.ONES_LIMIT(ONES_LIMIT)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[2]),
    .cs_n_s   (pins_s[1]),
    .din_s    (pins_s[0]),
    .rd_word  (rd_word),
    .rd_sel   (rd_sel),
    .wr_stb   (wr_stb),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_done  (rd_done),
    .ones_rst (ones_rst),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  sif_regfile u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_done     (rd_done),
    .ones_rst    (ones_rst),
    .conv_active (conv_active),
    .upd_valid   (upd_valid),
    .upd_data    (upd_data),
    .rd_sel      (rd_sel),
    .rd_word     (rd_word),
    .cfg_q       (cfg_q),
    .flt_q       (flt_q),
    .rdy_n       (rdy_n)
  );
endmodule

// File: tb/test_serial_regport.sv
module test_serial_regport;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic        conv_active = 1'b0, upd_valid = 1'b0;
  logic [15:0] upd_data = '0;
  logic        dout, dout_oe, rdy_n;
  logic [23:0] cfg_q;
  logic [7:0]  flt_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_regport i_serial_regport (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .conv_active(conv_active),
    .upd_valid(upd_valid), .upd_data(upd_data), .rdy_n(rdy_n),
    .cfg_q(cfg_q), .flt_q(flt_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open();
    @(negedge clk); cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic frame_close();
    wait_clk(HALF); cs_n = 1'b1; din = 1'b0; wait_clk(HALF);
  endtask

  // shifts n bits of wv MSB first, collects dout sampled just before each rising edge
  task automatic shift(input int n, input logic [31:0] wv, output logic [31:0] rv);
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; din = wv[i];
      wait_clk(HALF);
      rv = {rv[30:0], dout};
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic access(input logic [7:0] cmd, input int n, input logic [31:0] wv,
                        output logic [31:0] rv);
    logic [31:0] tmp;
    frame_open();
    shift(8, {24'h0, cmd}, tmp);
    shift(n, wv, rv);
    frame_close();
  endtask

  task automatic pulse_upd(input logic [15:0] v);
    @(negedge clk); upd_data = v; upd_valid = 1'b1;
    @(negedge clk); upd_valid = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    wait_clk(180000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, tmp;
    logic [23:0] pat;
    logic [7:0]  keep;
    wait_clk(4); rst = 1'b0; wait_clk(2);

    // R1 reset state
    chk("R1 cfg_q", {8'h0, cfg_q}, 32'h0);
    chk("R1 flt_q", {24'h0, flt_q}, 32'h45);
    chk("R1 rdy_n", {31'h0, rdy_n}, 32'h1);
    chk("R1 dout_oe", {31'h0, dout_oe}, 32'h0);
    access(8'h43, 16, 0, rv); chk("R1 result read", rv, 32'h0);
    access(8'h42, 8, 0, rv);  chk("R1 R3 filter read", rv, 32'h45);

    // R4 output enable follows select
    @(negedge clk); cs_n = 1'b0; wait_clk(6);
    chk("R4 dout_oe low select", {31'h0, dout_oe}, 32'h1);
    cs_n = 1'b1; wait_clk(6);
    chk("R4 dout_oe high select", {31'h0, dout_oe}, 32'h0);

    // R5 R2 R3 configuration sweep: walking ones and fixed patterns
    for (int i = 0; i < 27; i++) begin
      pat = (i < 24) ? (24'h1 << i) : (i == 24) ? 24'hA5C3E1 : (i == 25) ? 24'h5A3C1E : 24'hFFFFFF;
      access((i == 25) ? 8'hBD : 8'h01, 24, {8'h0, pat}, rv);
      chk("R5 cfg_q", {8'h0, cfg_q}, {8'h0, pat});
      access(8'h41, 24, 0, rv);
      chk("R2 R3 cfg read", rv, {8'h0, pat});
    end

    // R6 filter writes in standby, sweep, command with ignored bits 22h
    for (int v = 0; v < 256; v += 17) begin
      access(8'h22, 8, v, rv);
      chk("R6 flt_q standby", {24'h0, flt_q}, v);
      access(8'h42, 8, 0, rv);
      chk("R2 filter read", rv, v);
    end
    keep = flt_q;
    conv_active = 1'b1;
    access(8'h02, 8, 32'h0D, rv);
    chk("R6 refused while active", {24'h0, flt_q}, {24'h0, keep});
    conv_active = 1'b0;
    access(8'h02, 8, 32'h0D, rv);
    chk("R6 accepted in standby", {24'h0, flt_q}, 32'h0D);

    // R7 read-only targets
    access(8'h03, 16, 32'hBEEF, rv);
    access(8'h43, 16, 0, rv); chk("R7 result unchanged", rv, 32'h0);
    access(8'h00, 8, 32'hFF, rv);
    access(8'h40, 8, 0, rv);  chk("R7 status unchanged", rv, 32'h0);
    chk("R7 rdy_n unchanged", {31'h0, rdy_n}, 32'h1);

    // R8 R9 update and read sweep
    foreach (pat[k]) begin end
    for (int j = 0; j < 4; j++) begin
      logic [15:0] uv;
      uv = (j == 0) ? 16'h1234 : (j == 1) ? 16'hFFFF : (j == 2) ? 16'h8000 : 16'h0000;
      pulse_upd(uv);
      chk("R8 rdy_n low after update", {31'h0, rdy_n}, 32'h0);
      access(8'h40, 8, 0, rv); chk("R8 status ready", rv, 32'h80);
      access(8'h43, 16, 0, rv); chk("R9 R3 result read", rv, {16'h0, uv});
      chk("R9 rdy_n high after read", {31'h0, rdy_n}, 32'h1);
      access(8'h40, 8, 0, rv); chk("R8 status cleared", rv, 32'h0);
      access(8'h43, 16, 0, rv); chk("R9 reread", rv, {16'h0, uv});
    end

    // R10 snapshot across mid-read update
    pulse_upd(16'h1111);
    frame_open();
    shift(12, 32'h430, tmp);
    pulse_upd(16'h2222);
    shift(12, 0, rv);
    frame_close();
    chk("R10 snapshot word", {16'h0, tmp[3:0], rv[11:0]}, 32'h1111);
    chk("R9 ready cleared after read", {31'h0, rdy_n}, 32'h1);
    access(8'h43, 16, 0, rv); chk("R10 new value next read", rv, 32'h2222);

    // R12 abort mid-transfer and mid-command
    access(8'h01, 24, 32'h00C0FFEE, rv);
    frame_open(); shift(18, 32'h0107FF, tmp); frame_close();
    chk("R12 no write on abort", {8'h0, cfg_q}, 32'hC0FFEE);
    frame_open(); shift(4, 32'h4, tmp); frame_close();
    access(8'h41, 24, 0, rv); chk("R12 fresh command", rv, 32'hC0FFEE);

    // R11 31 ones do not reset, 32 do
    access(8'h22, 8, 32'h77, rv);
    pulse_upd(16'h4321);
    frame_open();
    shift(32, 32'h01FFFFFF, tmp);
    shift(8, 32'hFD, tmp);
    shift(24, 0, rv);
    frame_close();
    chk("R11 31 ones no reset read", rv, 32'hFFFFFF);
    chk("R11 31 ones flt kept", {24'h0, flt_q}, 32'h77);
    frame_open();
    shift(32, 32'hFFFFFFFF, tmp);
    shift(16, 32'h4200, rv);
    frame_close();
    chk("R11 read right after ones", {24'h0, rv[7:0]}, 32'h45);
    chk("R11 cfg reset", {8'h0, cfg_q}, 32'h0);
    chk("R11 flt reset", {24'h0, flt_q}, 32'h45);
    chk("R11 rdy_n reset", {31'h0, rdy_n}, 32'h1);
    access(8'h43, 16, 0, rv); chk("R11 result reset", rv, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule